// File: doc/BRIEF.md
# Address Line Fault Tester

This block is a self-test engine that hunts for open or shorted address lines between a bus master and a memory. Such faults make two distinct addresses land on one physical word, so the engine exercises only a small set of locations: a base address and, for every tested address bit, the base plus that bit's power-of-two offset. It assumes the data lines were already proven good by an earlier test. The scan of every memory cell belongs to a separate engine and is not done here.

After a start pulse the engine runs three phases. In the first it writes a fixed pattern to every power-of-two offset and the bitwise complement of that pattern to the base. In the second it reads the offsets back. In the third it takes each offset in turn, writes the complement there, reads the base and every other offset to confirm that none of them changed, and then writes the pattern back. The engine stops at the first mismatch and reports the address that exposed the fault. The done and fail flags and the reported address stay on the outputs until the next start.

The memory side is a single-outstanding request/grant port. A request holds until it is granted. A read then completes when the memory raises a read-valid strobe with the data.

Top module: `addr_line_tester`

## Requirements
- R1: After a synchronous active-low reset, busy, done, fail and mem_req are 0 and fail_addr is 0.
- R2: A start pulse while the engine is idle or done launches a new run: it latches base_addr, clears done, fail and fail_addr, and raises busy. A start or a base_addr change while busy has no effect on the run.
- R3: mem_req, mem_we, mem_addr and mem_wdata hold steady until mem_gnt is sampled high. A granted read completes when mem_rvalid arrives, and only one access is ever outstanding.
- R4: Phase 1 writes PATTERN (default binary 10 repeated, e.g. 0xAAAAAAAA) to base+2^i for i = 0 up to TEST_BITS-1 in ascending order, then writes ~PATTERN to base.
- R5: Phase 2 reads base+2^i in ascending order. The first read that differs from PATTERN ends the run with fail=1 and fail_addr equal to the address read.
- R6: Phase 3, for each j ascending: it writes ~PATTERN to base+2^j, reads base (expect ~PATTERN), reads base+2^k for every k other than j in ascending order (expect PATTERN), then writes PATTERN back to base+2^j.
- R7: The first phase-3 read mismatch ends the run with fail=1 and fail_addr = base+2^j for the offset j currently under test. No further memory access is made after a run ends.
- R8: A run with no mismatch ends with done=1, fail=0 and fail_addr=0. fail is never 1 without done.
- R9: done, fail and fail_addr stay constant until the next accepted start.
- R10: Address sums base+2^i wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a run when not busy |
| base_addr | input | ADDR_W | Base of the tested region, latched at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | Run found a fault, held until next start |
| fail_addr | output | ADDR_W | Address that exposed the fault, 0 on pass |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
The engine runs against a bench memory model whose address decode can be damaged in several ways. The clean decode is tried at a low base and at a base near the top of the space, which exercises the wrap in the address sums. A line stuck high and a line stuck low both fold one offset onto the base, so phase 2 catches them. A wired-AND short does the same, while a wired-OR short folds two offsets onto an untested word and only phase 3 can find it. Random grant and read-latency patterns show that the access order and the results do not depend on memory timing. A start pulse in mid-run, a restart after a failing run and a wait after done check that the outputs are held and cleared correctly.

// File: rtl/abt_pkg.sv
// Package: shared state encodings for the address line tester.
// Assumes nothing beyond IEEE 1800-2017 enums.
package abt_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_P1_WR,
        SQ_P1_BASE,
        SQ_P2_RD,
        SQ_P3_WR,
        SQ_P3_RDB,
        SQ_P3_RD,
        SQ_P3_RST,
        SQ_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PT_IDLE,
        PT_REQ,
        PT_WAIT
    } port_state_e;

endpackage

// File: rtl/abt_addr_sel.sv
// Module: forms base + 2^idx, or the base alone, modulo 2^ADDR_W.
// Assumes TEST_BITS <= ADDR_W and idx < TEST_BITS when use_base is low.
module abt_addr_sel #(
    parameter int ADDR_W    = 16,
    parameter int TEST_BITS = 10,
    parameter int IDX_W     = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic              use_base,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] offset;

    // One decoded offset bit per tested address line.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_off
        if (b < TEST_BITS) begin : g_live
            assign offset[b] = !use_base && (idx == IDX_W'(b));
        end else begin : g_dead
            assign offset[b] = 1'b0;
        end
    end

    // Wrapping sum of base and the selected offset.
    assign addr = base + offset;

endmodule

// File: rtl/abt_mem_port.sv
// Module: issues one memory access at a time over a request/grant port
// and returns a one-cycle completion pulse with any read data.
// Assumes op_start is raised only while the port is idle.
module abt_mem_port
    import abt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_we,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              op_done,
    output logic [DATA_W-1:0] op_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    port_state_e st;

    // Access state, latched request fields and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= PT_IDLE;
            op_done   <= 1'b0;
            op_rdata  <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            op_done <= 1'b0;
            case (st)
                PT_IDLE: if (op_start) begin
                    mem_we    <= op_we;
                    mem_addr  <= op_addr;
                    mem_wdata <= op_wdata;
                    st        <= PT_REQ;
                end
                PT_REQ: if (mem_gnt) begin
                    if (mem_we) begin
                        op_done <= 1'b1;
                        st      <= PT_IDLE;
                    end else begin
                        st <= PT_WAIT;
                    end
                end
                PT_WAIT: if (mem_rvalid) begin
                    op_rdata <= mem_rdata;
                    op_done  <= 1'b1;
                    st       <= PT_IDLE;
                end
                default: st <= PT_IDLE;
            endcase
        end
    end

    // Request is live only while waiting for the grant.
    assign mem_req = (st == PT_REQ);

    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))
        else $error("R3: request changed before grant");

    a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> st == PT_WAIT)
        else $error("R3: read data without an outstanding read");

endmodule

// File: rtl/abt_seq.sv
// Module: three-phase sequencer for the power-of-two address test.
// Chooses each access, checks read data and records the first failure.
// Assumes TEST_BITS >= 2 and a port that completes every access it starts.
module abt_seq
    import abt_pkg::*;
#(
    parameter int              DATA_W    = 32,
    parameter int              TEST_BITS = 10,
    parameter int              IDX_W     = 4,
    parameter logic [DATA_W-1:0] PATTERN = {(DATA_W/2){2'b10}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_done,
    input  logic [DATA_W-1:0] op_rdata,
    output logic              op_start,
    output logic              op_we,
    output logic [DATA_W-1:0] op_wdata,
    output logic [IDX_W-1:0]  idx,
    output logic              use_base,
    output logic              accept,
    output logic              fail_set,
    output logic [IDX_W-1:0]  fail_idx,
    output logic              busy,
    output logic              done,
    output logic              fail
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(TEST_BITS - 1);
    localparam logic [DATA_W-1:0] ANTI = ~PATTERN;

    seq_state_e        st;
    logic              pend;
    logic [IDX_W-1:0]  i_q, j_q;
    logic              fail_q;
    logic [DATA_W-1:0] expect_d;
    logic              is_read, mismatch;
    logic [IDX_W:0]    k_next;

    // Status decoded from the phase state.
    assign busy   = (st != SQ_IDLE) && (st != SQ_DONE);
    assign done   = (st == SQ_DONE);
    assign fail   = fail_q;
    assign accept = start && !busy;

    // Per-state access selection and expected read value.
    always_comb begin
        op_we    = 1'b0;
        op_wdata = PATTERN;
        idx      = i_q;
        use_base = 1'b0;
        expect_d = PATTERN;
        is_read  = 1'b0;
        case (st)
            SQ_P1_WR:   begin op_we = 1'b1; end
            SQ_P1_BASE: begin op_we = 1'b1; op_wdata = ANTI; use_base = 1'b1; end
            SQ_P2_RD:   begin is_read = 1'b1; end
            SQ_P3_WR:   begin op_we = 1'b1; op_wdata = ANTI; idx = j_q; end
            SQ_P3_RDB:  begin is_read = 1'b1; use_base = 1'b1; expect_d = ANTI; end
            SQ_P3_RD:   begin is_read = 1'b1; end
            SQ_P3_RST:  begin op_we = 1'b1; idx = j_q; end
            default:    ;
        endcase
    end

    assign op_start = busy && !pend;
    assign mismatch = is_read && (op_rdata != expect_d);
    assign fail_set = op_done && mismatch;
    assign fail_idx = (st == SQ_P2_RD) ? i_q : j_q;

    // Next neighbour offset in phase 3, skipping the one under test.
    always_comb begin
        k_next = {1'b0, i_q} + 1'b1;
        if (k_next == {1'b0, j_q}) k_next = k_next + 1'b1;
    end

    // Phase sequencing, offset counters and failure flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            pend   <= 1'b0;
            i_q    <= '0;
            j_q    <= '0;
            fail_q <= 1'b0;
        end else if (accept) begin
            st     <= SQ_P1_WR;
            pend   <= 1'b0;
            i_q    <= '0;
            j_q    <= '0;
            fail_q <= 1'b0;
        end else begin
            if (op_start) pend <= 1'b1;
            if (op_done) begin
                pend <= 1'b0;
                if (mismatch) begin
                    fail_q <= 1'b1;
                    st     <= SQ_DONE;
                end else begin
                    case (st)
                        SQ_P1_WR:
                            if (i_q == LAST) st <= SQ_P1_BASE;
                            else i_q <= i_q + 1'b1;
                        SQ_P1_BASE: begin
                            i_q <= '0;
                            st  <= SQ_P2_RD;
                        end
                        SQ_P2_RD:
                            if (i_q == LAST) begin
                                j_q <= '0;
                                st  <= SQ_P3_WR;
                            end else begin
                                i_q <= i_q + 1'b1;
                            end
                        SQ_P3_WR: st <= SQ_P3_RDB;
                        SQ_P3_RDB: begin
                            i_q <= (j_q == '0) ? IDX_W'(1) : '0;
                            st  <= SQ_P3_RD;
                        end
                        SQ_P3_RD:
                            if (k_next >= (IDX_W+1)'(TEST_BITS)) st <= SQ_P3_RST;
                            else i_q <= k_next[IDX_W-1:0];
                        SQ_P3_RST:
                            if (j_q == LAST) st <= SQ_DONE;
                            else begin
                                j_q <= j_q + 1'b1;
                                st  <= SQ_P3_WR;
                            end
                        default: st <= SQ_IDLE;
                    endcase
                end
            end
        end
    end

    a_r8_fail_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done)
        else $error("R8: fail without done");

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(fail))
        else $error("R9: result changed without start");

    a_r2_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !op_done |=> busy)
        else $error("R2: start disturbed a running test");

endmodule

// File: rtl/addr_line_tester.sv
// Module: top of the address line tester. It latches the base, wires the
// sequencer to the memory port and records the failing address.
// Assumes the data lines were verified beforehand and TEST_BITS <= ADDR_W.
module addr_line_tester #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter int                TEST_BITS = 10,
    parameter logic [DATA_W-1:0] PATTERN   = {(DATA_W/2){2'b10}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_W = $clog2(TEST_BITS + 2);

    logic [ADDR_W-1:0] base_q, op_addr, bad_addr;
    logic [DATA_W-1:0] op_wdata, op_rdata;
    logic [IDX_W-1:0]  idx, fail_idx;
    logic              op_start, op_we, op_done, use_base, accept, fail_set;

    // Base latch and failure address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            fail_addr <= '0;
        end else if (accept) begin
            base_q    <= base_addr;
            fail_addr <= '0;
        end else if (fail_set) begin
            fail_addr <= bad_addr;
        end
    end

    abt_seq #(
        .DATA_W(DATA_W), .TEST_BITS(TEST_BITS), .IDX_W(IDX_W), .PATTERN(PATTERN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_done(op_done), .op_rdata(op_rdata),
        .op_start(op_start), .op_we(op_we), .op_wdata(op_wdata),
        .idx(idx), .use_base(use_base), .accept(accept),
        .fail_set(fail_set), .fail_idx(fail_idx),
        .busy(busy), .done(done), .fail(fail)
    );

    abt_addr_sel #(.ADDR_W(ADDR_W), .TEST_BITS(TEST_BITS), .IDX_W(IDX_W)) u_acc_addr (
        .base(base_q), .idx(idx), .use_base(use_base), .addr(op_addr)
    );

    abt_addr_sel #(.ADDR_W(ADDR_W), .TEST_BITS(TEST_BITS), .IDX_W(IDX_W)) u_bad_addr (
        .base(base_q), .idx(fail_idx), .use_base(1'b0), .addr(bad_addr)
    );

    abt_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .op_start(op_start), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
        .op_done(op_done), .op_rdata(op_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req)
        else $error("R7: memory access after run ended");

    a_r4_write_values: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_wdata == PATTERN) || (mem_wdata == ~PATTERN))
        else $error("R4: unexpected write data");

    a_r5_fail_addr_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $countones(fail_addr - base_q) == 1)
        else $error("R5/R7: failing address is not a tested offset");

endmodule

// File: tb/tb_addr_line_tester.sv
module tb_addr_line_tester;

    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int TBN = 8;
    localparam logic [DW-1:0] PAT = {(DW/2){2'b10}};

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } acc_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_gnt = 1'b0;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    // fault model: 0 none, 1 stuck high, 2 stuck low, 3 wired-AND short, 4 wired-OR short
    int fmode = 0;
    int fa = 0;
    int fb = 1;

    logic [DW-1:0] bmem [logic [AW-1:0]];
    logic [DW-1:0] rmem [logic [AW-1:0]];
    acc_t          exp_q[$];
    logic          exp_fail;
    logic [AW-1:0] exp_addr;
    int            trace_err;
    string         trace_msg;

    logic          rd_pend = 1'b0;
    int            rd_dly = 0;
    logic [DW-1:0] rd_data = '0;

    always #2 clk = ~clk;

    addr_line_tester #(.ADDR_W(AW), .DATA_W(DW), .TEST_BITS(TBN), .PATTERN(PAT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
        logic [AW-1:0] p;
        logic v;
        p = a;
        case (fmode)
            1: p[fa] = 1'b1;
            2: p[fa] = 1'b0;
            3: begin v = a[fa] & a[fb]; p[fa] = v; p[fb] = v; end
            4: begin v = a[fa] | a[fb]; p[fa] = v; p[fb] = v; end
            default: ;
        endcase
        return p;
    endfunction

    function automatic logic [AW-1:0] off(input logic [AW-1:0] b, input int i);
        return b + AW'(1 << i);
    endfunction

    function automatic logic [DW-1:0] rref(input logic [AW-1:0] a);
        logic [AW-1:0] p;
        p = phys(a);
        return rmem.exists(p) ? rmem[p] : '0;
    endfunction

    task automatic push_w(input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_q.push_back('{we: 1'b1, addr: a, data: d});
        rmem[phys(a)] = d;
    endtask

    task automatic push_r(input logic [AW-1:0] a);
        exp_q.push_back('{we: 1'b0, addr: a, data: '0});
    endtask

    // Reference run of the three phases per R4..R8 on the faulty decode.
    task automatic ref_build(input logic [AW-1:0] b);
        exp_q.delete();
        rmem.delete();
        exp_fail = 1'b0;
        exp_addr = '0;
        for (int i = 0; i < TBN; i++) push_w(off(b, i), PAT);
        push_w(b, ~PAT);
        for (int i = 0; i < TBN; i++) begin
            push_r(off(b, i));
            if (rref(off(b, i)) != PAT) begin
                exp_fail = 1'b1; exp_addr = off(b, i); return;
            end
        end
        for (int j = 0; j < TBN; j++) begin
            push_w(off(b, j), ~PAT);
            push_r(b);
            if (rref(b) != ~PAT) begin
                exp_fail = 1'b1; exp_addr = off(b, j); return;
            end
            for (int k = 0; k < TBN; k++) begin
                if (k == j) continue;
                push_r(off(b, k));
                if (rref(off(b, k)) != PAT) begin
                    exp_fail = 1'b1; exp_addr = off(b, j); return;
                end
            end
            push_w(off(b, j), PAT);
        end
    endtask

    // Memory responder: random grant, random read latency, trace compare.
    always @(negedge clk) begin
        mem_gnt    = 1'b0;
        mem_rvalid = 1'b0;
        if (rd_pend) begin
            if (rd_dly == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd_data;
                rd_pend    = 1'b0;
            end else begin
                rd_dly--;
            end
        end else if (rst_n && mem_req && ($urandom % 4 != 0)) begin
            acc_t e;
            logic [AW-1:0] p;
            mem_gnt = 1'b1;
            if (exp_q.size() == 0) begin
                if (trace_err == 0)
                    trace_msg = $sformatf("unexpected access we=%0b addr=%h", mem_we, mem_addr);
                trace_err++;
            end else begin
                e = exp_q.pop_front();
                if (e.we != mem_we || e.addr != mem_addr || (e.we && e.data != mem_wdata)) begin
                    if (trace_err == 0)
                        trace_msg = $sformatf("got we=%0b addr=%h data=%h exp we=%0b addr=%h data=%h",
                                              mem_we, mem_addr, mem_wdata, e.we, e.addr, e.data);
                    trace_err++;
                end
            end
            p = phys(mem_addr);
            if (mem_we) begin
                bmem[p] = mem_wdata;
            end else begin
                rd_pend = 1'b1;
                rd_dly  = $urandom % 3;
                rd_data = bmem.exists(p) ? bmem[p] : '0;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // One full run; mid_start pulses start and moves base_addr while busy (R2).
    task automatic run(input logic [AW-1:0] b, input int mode, input int a1, input int a2,
                       input bit mid_start, input string tag);
        int n;
        fmode = mode; fa = a1; fb = a2;
        bmem.delete();
        ref_build(b);
        trace_err = 0;
        trace_msg = "";
        @(negedge clk);
        base_addr = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({"R2 busy after start ", tag}, 64'(busy), 64'd1);
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
            if (mid_start && n == 40) begin start = 1'b1; base_addr = b ^ 16'h0F0F; end
            if (mid_start && n == 41) start = 1'b0;
        end
        check({"R8 done reached ", tag}, 64'(done), 64'd1);
        check({"R4 R6 R7 access order ", tag}, 64'(trace_err), 64'd0);
        if (trace_err != 0) $display("  trace: %s", trace_msg);
        check({"R4 R6 R7 no missing access ", tag}, 64'(exp_q.size()), 64'd0);
        check({"R5 R7 R8 fail flag ", tag}, 64'(fail), 64'(exp_fail));
        check({"R5 R7 R10 fail_addr ", tag}, 64'(fail_addr), 64'(exp_addr));
        repeat (12) @(negedge clk);
        check({"R9 done held ", tag}, {62'd0, done, fail}, {62'd0, 1'b1, exp_fail});
        check({"R9 fail_addr held ", tag}, 64'(fail_addr), 64'(exp_addr));
        check({"R7 no access after end ", tag}, 64'(exp_q.size() + trace_err), 64'd0);
    endtask

    initial begin
        int wd_hit;
        wd_hit = 0;
        fork
            begin
                repeat (190000) @(posedge clk);
                wd_hit = 1;
            end
            begin
                process::self().srandom(32'h5EED_0A11);
                repeat (3) @(negedge clk);
                check("R1 reset outputs", {60'd0, busy, done, fail, mem_req}, 64'd0);
                check("R1 reset fail_addr", 64'(fail_addr), 64'd0);
                rst_n = 1'b1;
                @(negedge clk);
                check("R1 idle after reset", {61'd0, busy, done, mem_req}, 64'd0);

                run(16'h0000, 0, 0, 1, 1'b0, "clean base0");
                run(16'hFFF0, 0, 0, 1, 1'b0, "clean wrap R10");
                run(16'h0000, 2, 3, 0, 1'b0, "stuck-low bit3");
                run(16'h1000, 1, 5, 0, 1'b0, "stuck-high bit5");
                run(16'h0000, 4, 2, 5, 1'b0, "wired-OR 2,5");
                run(16'h0200, 3, 1, 6, 1'b0, "wired-AND 1,6");
                run(16'h0400, 0, 0, 1, 1'b1, "start while busy");
                for (int r = 0; r < 10; r++) begin
                    int m, x, y;
                    m = $urandom % 5;
                    x = $urandom % TBN;
                    y = (x + 1 + ($urandom % (TBN - 1))) % TBN;
                    run(AW'($urandom) & 16'hFF00, m, x, y, 1'b0, $sformatf("random %0d", r));
                end
            end
        join_any
        disable fork;
        if (wd_hit) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule